// File: doc/BRIEF.md
# Character Display Command Controller

This block carries out the instructions of a two-line, forty-column character display. It receives byte transactions that an outer bus adapter has already assembled. Each byte carries a register-select bit (instruction side or data side) and a direction bit (write or read). The block holds the address counter, the 80-entry display memory and the 64-row user glyph memory. It also holds the entry mode, the horizontal shift offset, the on/cursor/blink flags, the bus-width flag and the brightness code. It answers status and memory reads one cycle after the request.

The only long operation is clearing the display memory. It runs at power-on and on the clear instruction. The block writes a blank (20h) into one location per cycle and raises `busy` for the whole walk. A renderer outside the block reads characters through a combinational scan port. It places them using `shiftOff`: panel column p shows memory column (p + shiftOff) mod 40 on both lines. It uses `blinkLit` to draw the character under the cursor as all dots on.

Display addresses are 7 bits. Bit 6 selects the line, and bits 5..0 give the column, which is valid from 0 to 39. Glyph addresses are 6 bits.

Top module: `charDispCore`

## Requirements
- R1: While reset is held and during the first 80 cycles after it is released, busy is 1. Every display location then reads 20h. The outputs then show display off, cursor off, blink dark, 8-bit width (wideBus=1), brightness 00, shift 0, address 00h and display memory selected.
- R2: Instruction 01h starts the same 80-cycle blank fill with busy high. It also sets the address to 00h, selects display memory, sets shift to 0 and forces increment mode.
- R3: While busy, every transaction except a status read is dropped with no effect on any state.
- R4: A status read (RS=0, read) returns {busy, address[6:0]} on rdData, with rdValid high, in the cycle after the request.
- R5: An instruction with bit 7 set loads bits 6..0 into the address and selects display memory. Each increment step goes from column 39 to column 0 of the other line (27h to 40h, 67h to 00h). Each decrement step goes from column 0 to column 39 of the other line.
- R6: An instruction of the form 01xxxxxx loads a 6-bit glyph address and selects glyph memory. Glyph steps wrap between 3Fh and 00h. A glyph write stores data bits 4..0, and a glyph read returns them with bits 7..5 zero.
- R7: A data read (RS=1, read) returns the selected memory at the address one cycle later. It then steps the address by the entry direction and never changes the shift.
- R8: Instruction 000001ab sets the direction (a=1 increment) and the write-shift enable (b). With b=1, a display-memory write still steps the address. It also moves the shift by +1 mod 40 when incrementing and by -1 mod 40 when decrementing.
- R9: Instruction 0001sr?? touches no memory. With s=0 it steps the address (r=1 up, r=0 down). With s=1 it leaves the address unchanged and moves the shift by -1 (r=1) or +1 (r=0) mod 40.
- R10: Instruction 001w???? sets wideBus to w and arms brightness capture. If the next accepted non-status transaction is an RS=1 write, it loads brightness from data bits 1..0 and neither writes memory nor steps the address. An RS=0 write arriving first disarms the capture.
- R11: Instruction 00001dcb sets dispOn=d, cursorOn=c and blink enable=b.
- R12: While blink is enabled, blinkLit starts dark and toggles every BLINK_HALF cycles. It is 0 in the cycle after blink is disabled.
- R13: Instruction 0000001x sets the address to 00h, selects display memory and sets shift to 0, leaving memory unchanged.
- R14: scanChar returns the display character at scanAddr in the same cycle, and 20h for columns 40 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transaction present this cycle |
| reqRs | input | 1 | 0 instruction side, 1 data side |
| reqRead | input | 1 | 1 read, 0 write |
| reqData | input | 8 | Write byte |
| rdValid | output | 1 | Read result present |
| rdData | output | 8 | Read result |
| busy | output | 1 | Blank fill in progress |
| acAddr | output | 7 | Address counter |
| cgSel | output | 1 | Address points at glyph memory |
| shiftOff | output | 6 | Horizontal shift offset |
| dispOn | output | 1 | Display enable |
| cursorOn | output | 1 | Cursor enable |
| blinkLit | output | 1 | Blink phase, all-dots-on when 1 |
| brightness | output | 2 | 00 full, 01 three quarters, 10 half, 11 quarter |
| wideBus | output | 1 | 1 eight-bit bus width, 0 four-bit |
| scanAddr | input | 7 | Renderer display address |
| scanChar | output | 8 | Character at scanAddr |

## Verification
The blank-fill walk and an incoming transaction can land in the same cycle. The walk owns the memory write port, while the request decoder would otherwise update the address, modes or memory. The bench provokes this by issuing a bus-width instruction and a status read right behind a clear. It judges the result by three observations: wideBus is unchanged, the status byte has bit 7 set, and the fill still lasts exactly 80 cycles, after which every location is blank and the address is 00h.

// File: rtl/charDispPkg.sv
package charDispPkg;

  localparam int ADDR_W = 7;
  localparam int CG_AW  = 6;
  localparam int CG_DEPTH = 1 << CG_AW;

  typedef enum logic [1:0] {
    RD_STATUS,
    RD_DD,
    RD_CG,
    RD_BLANK
  } rdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              clrWe;
    logic [ADDR_W-1:0] clrIdx;
    logic              ddWe;
    logic [ADDR_W-1:0] ddIdx;
    logic              cgWe;
    logic [CG_AW-1:0]  cgIdx;
    logic [7:0]        wData;
    logic              rdStb;
    rdKind_e           rdKind;
    logic [7:0]        statusWord;
  } dpStb_t;

  // line bit selects the upper half of the flat memory
  function automatic logic [ADDR_W-1:0] ddIndex(input logic [ADDR_W-1:0] addr,
                                                input logic [5:0] nCols);
    logic [ADDR_W-1:0] colPart;
    colPart = {1'b0, addr[5:0]};
    return addr[6] ? ({1'b0, nCols} + colPart) : colPart;
  endfunction

endpackage

// File: rtl/charDispBlink.sv
module charDispBlink #(
  parameter int BLINK_HALF = 62_500_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  output logic lit
);
  localparam int BC_W = (BLINK_HALF > 2) ? $clog2(BLINK_HALF) : 1;
  localparam logic [BC_W-1:0] LAST_TICK = BC_W'(BLINK_HALF - 1);

  logic [BC_W-1:0] tick;
  logic            phase;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      tick  <= '0;
      phase <= 1'b0;
    end else if (tick == LAST_TICK) begin
      tick  <= '0;
      phase <= ~phase;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  assign lit = phase;

  AST_BLINK_DARK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !lit); // R12

endmodule

// File: rtl/charDispCtrl.sv
module charDispCtrl
  import charDispPkg::*;
#(
  parameter int COLS = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqRs,
  input  logic              reqRead,
  input  logic [7:0]        reqData,
  output dpStb_t            stb,
  output logic              busy,
  output logic [ADDR_W-1:0] acAddr,
  output logic              cgSel,
  output logic [5:0]        shiftOff,
  output logic              dispOn,
  output logic              cursorOn,
  output logic              blinkOn,
  output logic [1:0]        brightness,
  output logic              wideBus
);
  localparam int DD_SIZE = 2 * COLS;
  localparam logic [5:0]        LAST_COL = 6'(COLS - 1);
  localparam logic [ADDR_W-1:0] LAST_CLR = ADDR_W'(DD_SIZE - 1);

  logic              clrActive;
  logic [ADDR_W-1:0] clrCnt;
  logic              entryInc;
  logic              entryShift;
  logic              brtPend;

  // request classification
  logic isStatus, accept, cmdWr, datWr, datRd, brtCap, ramWr;
  assign isStatus = !reqRs && reqRead;
  assign accept   = reqValid && (!clrActive || isStatus);
  assign cmdWr    = accept && !reqRs && !reqRead;
  assign datWr    = accept && reqRs && !reqRead;
  assign datRd    = accept && reqRs && reqRead;
  assign brtCap   = datWr && brtPend;
  assign ramWr    = datWr && !brtPend;

  logic isShiftCmd, isFuncCmd;
  assign isShiftCmd = cmdWr && (reqData[7:4] == 4'b0001);
  assign isFuncCmd  = cmdWr && (reqData[7:5] == 3'b001);

  // address stepping
  logic stepEn, stepUp;
  assign stepEn = ramWr || datRd || (isShiftCmd && !reqData[3]);
  assign stepUp = isShiftCmd ? reqData[2] : entryInc;

  logic [5:0]        acCol;
  logic              acLine;
  logic              ddValid;
  logic [ADDR_W-1:0] acNext;
  assign acCol   = acAddr[5:0];
  assign acLine  = acAddr[6];
  assign ddValid = acCol <= LAST_COL;

  always_comb begin
    if (cgSel) begin
      acNext = stepUp ? {1'b0, acCol + 6'd1} : {1'b0, acCol - 6'd1};
    end else if (stepUp) begin
      acNext = (acCol >= LAST_COL) ? {~acLine, 6'd0} : {acLine, acCol + 6'd1};
    end else begin
      acNext = (acCol == 6'd0) ? {~acLine, LAST_COL} : {acLine, acCol - 6'd1};
    end
  end

  // display shift
  logic       shEn, shLeft;
  logic [5:0] shNext;
  assign shEn   = (ramWr && !cgSel && entryShift) || (isShiftCmd && reqData[3]);
  assign shLeft = isShiftCmd ? !reqData[2] : entryInc;

  always_comb begin
    if (shLeft) shNext = (shiftOff == LAST_COL) ? 6'd0 : shiftOff + 6'd1;
    else        shNext = (shiftOff == 6'd0) ? LAST_COL : shiftOff - 6'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrActive  <= 1'b1;
      clrCnt     <= '0;
      acAddr     <= '0;
      cgSel      <= 1'b0;
      shiftOff   <= '0;
      entryInc   <= 1'b1;
      entryShift <= 1'b0;
      dispOn     <= 1'b0;
      cursorOn   <= 1'b0;
      blinkOn    <= 1'b0;
      wideBus    <= 1'b1;
      brightness <= 2'b00;
      brtPend    <= 1'b0;
    end else begin
      if (clrActive) begin
        if (clrCnt == LAST_CLR) clrActive <= 1'b0;
        clrCnt <= clrCnt + 1'b1;
      end
      if (accept && !isStatus) brtPend <= isFuncCmd;
      if (brtCap) brightness <= reqData[1:0];
      if (stepEn) acAddr <= acNext;
      if (shEn) shiftOff <= shNext;
      if (cmdWr) begin
        casez (reqData)
          8'b1???????: begin
            acAddr <= reqData[6:0];
            cgSel  <= 1'b0;
          end
          8'b01??????: begin
            acAddr <= {1'b0, reqData[5:0]};
            cgSel  <= 1'b1;
          end
          8'b001?????: wideBus <= reqData[4];
          8'b00001???: begin
            dispOn   <= reqData[2];
            cursorOn <= reqData[1];
            blinkOn  <= reqData[0];
          end
          8'b000001??: begin
            entryInc   <= reqData[1];
            entryShift <= reqData[0];
          end
          8'b0000001?: begin
            acAddr   <= '0;
            cgSel    <= 1'b0;
            shiftOff <= '0;
          end
          8'b00000001: begin
            clrActive <= 1'b1;
            clrCnt    <= '0;
            acAddr    <= '0;
            cgSel     <= 1'b0;
            shiftOff  <= '0;
            entryInc  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    stb            = '0;
    stb.clrWe      = clrActive;
    stb.clrIdx     = clrCnt;
    stb.ddWe       = ramWr && !cgSel && ddValid;
    stb.ddIdx      = ddIndex(acAddr, 6'(COLS));
    stb.cgWe       = ramWr && cgSel;
    stb.cgIdx      = acAddr[CG_AW-1:0];
    stb.wData      = reqData;
    stb.rdStb      = (accept && isStatus) || datRd;
    stb.statusWord = {clrActive, acAddr};
    if (isStatus)     stb.rdKind = RD_STATUS;
    else if (cgSel)   stb.rdKind = RD_CG;
    else if (ddValid) stb.rdKind = RD_DD;
    else              stb.rdKind = RD_BLANK;
  end

  assign busy = clrActive;

  AST_CG_ADDR_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    cgSel |-> !acAddr[6]); // R6
  AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    shiftOff <= LAST_COL); // R8
  AST_DD_STEP_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !cgSel && ddValid) |=> (acAddr[5:0] <= LAST_COL)); // R5
  AST_FILL_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    clrActive |-> (clrCnt <= LAST_CLR)); // R2
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (clrActive && reqValid && !(!reqRs && reqRead)) |=>
      ($stable(acAddr) && $stable(wideBus) && $stable(brightness))); // R3

endmodule

// File: rtl/charDispData.sv
module charDispData
  import charDispPkg::*;
#(
  parameter int COLS = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStb_t            stb,
  output logic              rdValid,
  output logic [7:0]        rdData,
  input  logic [ADDR_W-1:0] scanAddr,
  output logic [7:0]        scanChar
);
  localparam int DD_SIZE = 2 * COLS;
  localparam logic [5:0] LAST_COL = 6'(COLS - 1);

  logic [7:0] ddRam [DD_SIZE];
  logic [4:0] cgRam [CG_DEPTH];

  always_ff @(posedge clk) begin
    if (stb.clrWe)     ddRam[stb.clrIdx] <= 8'h20;
    else if (stb.ddWe) ddRam[stb.ddIdx]  <= stb.wData;
    if (stb.cgWe) cgRam[stb.cgIdx] <= stb.wData[4:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdStb;
      if (stb.rdStb) begin
        case (stb.rdKind)
          RD_STATUS: rdData <= stb.statusWord;
          RD_DD:     rdData <= ddRam[stb.ddIdx];
          RD_CG:     rdData <= {3'b000, cgRam[stb.cgIdx]};
          default:   rdData <= 8'h20;
        endcase
      end
    end
  end

  assign scanChar = (scanAddr[5:0] <= LAST_COL) ? ddRam[ddIndex(scanAddr, 6'(COLS))]
                                                : 8'h20;

  logic rdReq;
  assign rdReq = stb.rdStb;

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.clrWe && stb.ddWe)); // R3
  AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdReq)); // R4

endmodule

// File: rtl/charDispCore.sv
module charDispCore
  import charDispPkg::*;
#(
  parameter int COLS       = 40,
  parameter int BLINK_HALF = 62_500_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqRs,
  input  logic       reqRead,
  input  logic [7:0] reqData,
  output logic       rdValid,
  output logic [7:0] rdData,
  output logic       busy,
  output logic [6:0] acAddr,
  output logic       cgSel,
  output logic [5:0] shiftOff,
  output logic       dispOn,
  output logic       cursorOn,
  output logic       blinkLit,
  output logic [1:0] brightness,
  output logic       wideBus,
  input  logic [6:0] scanAddr,
  output logic [7:0] scanChar
);
  dpStb_t stb;
  logic   blinkOn;

  charDispCtrl #(.COLS(COLS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqRs(reqRs), .reqRead(reqRead), .reqData(reqData),
    .stb(stb), .busy(busy), .acAddr(acAddr), .cgSel(cgSel),
    .shiftOff(shiftOff), .dispOn(dispOn), .cursorOn(cursorOn),
    .blinkOn(blinkOn), .brightness(brightness), .wideBus(wideBus)
  );

  charDispData #(.COLS(COLS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rdValid(rdValid), .rdData(rdData),
    .scanAddr(scanAddr), .scanChar(scanChar)
  );

  charDispBlink #(.BLINK_HALF(BLINK_HALF)) uBlink (
    .clk(clk), .rstN(rstN), .enable(blinkOn), .lit(blinkLit)
  );

endmodule

// File: tb/charDispCore_test.sv
module charDispCore_test;
  localparam int COLS = 40;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqRs = 1'b0, reqRead = 1'b0;
  logic [7:0] reqData = '0;
  logic rdValid, busy, cgSel, dispOn, cursorOn, blinkLit, wideBus;
  logic [7:0] rdData, scanChar;
  logic [6:0] acAddr;
  logic [6:0] scanAddr = '0;
  logic [5:0] shiftOff;
  logic [1:0] brightness;

  charDispCore #(.COLS(COLS), .BLINK_HALF(HALF)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRs(reqRs), .reqRead(reqRead),
    .reqData(reqData), .rdValid(rdValid), .rdData(rdData), .busy(busy),
    .acAddr(acAddr), .cgSel(cgSel), .shiftOff(shiftOff), .dispOn(dispOn),
    .cursorOn(cursorOn), .blinkLit(blinkLit), .brightness(brightness),
    .wideBus(wideBus), .scanAddr(scanAddr), .scanChar(scanChar)
  );

  always #4 clk = ~clk;

  int nChecks = 0, nFail = 0, cyc = 0;
  logic lastValid;
  logic [7:0] lastRd;
  logic [7:0] model [128];
  logic [4:0] cgModel [64];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic rs, input logic rd, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqRs = rs; reqRead = rd; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    lastValid = rdValid;
    lastRd = rdData;
  endtask

  function automatic logic [6:0] stepDd(input logic [6:0] a, input bit up);
    int col = int'(a[5:0]);
    int line = int'(a[6]);
    if (up) begin
      if (col >= COLS - 1) return 7'((1 - line) * 64);
      return 7'(line * 64 + col + 1);
    end
    if (col == 0) return 7'((1 - line) * 64 + COLS - 1);
    return 7'(line * 64 + col - 1);
  endfunction

  task automatic scanAll(input string tag);
    for (int a = 0; a < 128; a++) begin
      scanAddr = 7'(a);
      #1;
      chk(tag, scanChar, (a % 64 < COLS) ? model[a] : 8'h20);
    end
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int n, off, c0;
    logic [6:0] a;
    logic [7:0] d;
    for (int i = 0; i < 128; i++) model[i] = 8'h20;

    // R1: reset defaults and fill
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 1);
    rstN = 1'b1;
    waitIdle(n);
    chk("R1 fill length", n, 80);
    chk("R1 dispOn", dispOn, 0);
    chk("R1 cursorOn", cursorOn, 0);
    chk("R1 blink", blinkLit, 0);
    chk("R1 wideBus", wideBus, 1);
    chk("R1 brightness", brightness, 0);
    chk("R1 shift", shiftOff, 0);
    chk("R1 addr", {cgSel, acAddr}, 0);
    scanAll("R1 R14 blank");

    // R4: status read
    issue(0, 0, 8'h80 | 8'h25);
    issue(0, 1, 8'h00);
    chk("R4 status valid", lastValid, 1);
    chk("R4 status word", lastRd, 8'h25);

    // R5: increment sweep through both lines
    issue(0, 0, 8'h80);
    a = 7'h00;
    for (int i = 0; i < 80; i++) begin
      d = 8'(i + 48);
      issue(1, 0, d);
      model[a] = d;
      a = stepDd(a, 1);
      chk("R5 inc step", acAddr, a);
    end
    chk("R5 wrap 67h to 00h", acAddr, 0);
    scanAll("R14 scan after fill");

    // R7: decrement read sweep with shift enabled, reads never shift
    issue(0, 0, 8'h05);
    issue(0, 0, 8'h80 | 8'h67);
    a = 7'h67;
    for (int i = 0; i < 80; i++) begin
      issue(1, 1, 8'h00);
      chk("R7 read data", {lastValid, lastRd}, {1'b1, model[a]});
      a = stepDd(a, 0);
      chk("R5 R7 dec step", acAddr, a);
    end
    chk("R7 no shift on read", shiftOff, 0);

    // R8: write shift
    issue(0, 0, 8'h07);
    issue(0, 0, 8'h80);
    a = 7'h00;
    for (int i = 0; i < 45; i++) begin
      issue(1, 0, 8'h41);
      model[a] = 8'h41;
      a = stepDd(a, 1);
      chk("R8 shift left", shiftOff, (i + 1) % COLS);
      chk("R8 addr steps", acAddr, a);
    end
    off = 45 % COLS;
    issue(0, 0, 8'h05);
    issue(1, 0, 8'h42);
    model[a] = 8'h42;
    a = stepDd(a, 0);
    off = off - 1;
    chk("R8 shift right", shiftOff, off);
    chk("R8 dec addr", acAddr, a);

    // R9: shift instruction
    issue(0, 0, 8'h18);
    chk("R9 disp left", shiftOff, off + 1);
    chk("R9 addr held", acAddr, a);
    issue(0, 0, 8'h1C);
    chk("R9 disp right", shiftOff, off);
    issue(0, 0, 8'h14);
    a = stepDd(a, 1);
    chk("R9 cursor right", acAddr, a);
    chk("R9 shift held", shiftOff, off);
    issue(0, 0, 8'h10);
    a = stepDd(a, 0);
    chk("R9 cursor left", acAddr, a);

    // R13: home, then shift wrap below zero
    issue(0, 0, 8'h03);
    chk("R13 home addr", {cgSel, acAddr}, 0);
    chk("R13 home shift", shiftOff, 0);
    scanAll("R13 memory kept");
    issue(0, 0, 8'h1C);
    chk("R9 wrap to 39", shiftOff, COLS - 1);
    issue(0, 0, 8'h18);
    chk("R9 wrap to 0", shiftOff, 0);

    // R6: glyph memory
    issue(0, 0, 8'h06);
    issue(0, 0, 8'h40);
    for (int i = 0; i < 64; i++) begin
      d = 8'(i * 29 + 7);
      issue(1, 0, d);
      cgModel[i] = d[4:0];
      chk("R6 glyph step", {cgSel, acAddr}, {1'b1, 7'((i + 1) % 64)});
    end
    chk("R6 no shift on glyph", shiftOff, 0);
    for (int i = 0; i < 64; i++) begin
      issue(1, 1, 8'h00);
      chk("R6 glyph read", lastRd, {3'b000, cgModel[i]});
    end
    issue(0, 0, 8'h04);
    issue(0, 0, 8'h40);
    issue(1, 1, 8'h00);
    chk("R6 read row 0", lastRd, {3'b000, cgModel[0]});
    chk("R6 wrap 00h to 3Fh", acAddr, 7'h3F);
    issue(0, 1, 8'h00);
    chk("R4 status glyph", lastRd, 8'h3F);
    issue(0, 0, 8'h7F);
    chk("R6 load 3Fh", {cgSel, acAddr}, {1'b1, 7'h3F});

    // R10: bus width and brightness capture
    issue(0, 0, 8'h06);
    issue(0, 0, 8'h80 | 8'h05);
    for (int b = 0; b < 4; b++) begin
      issue(0, 0, 8'h20);
      chk("R10 narrow", wideBus, 0);
      issue(1, 0, 8'hFC | 8'(b));
      chk("R10 brightness", brightness, b);
      chk("R10 no step", acAddr, 7'h05);
    end
    scanAddr = 7'h05; #1;
    chk("R10 no memory write", scanChar, model[5]);
    issue(0, 0, 8'h30);
    chk("R10 wide", wideBus, 1);
    issue(0, 0, 8'h0C);
    issue(1, 0, 8'h01);
    model[5] = 8'h01;
    chk("R10 capture cancelled", brightness, 3);
    chk("R10 data to memory step", acAddr, 7'h06);
    scanAddr = 7'h05; #1;
    chk("R10 data to memory", scanChar, 8'h01);

    // R11: display flags
    for (int v = 8; v < 16; v++) begin
      issue(0, 0, 8'(v));
      chk("R11 dispOn", dispOn, (v >> 2) & 1);
      chk("R11 cursorOn", cursorOn, (v >> 1) & 1);
    end

    // R12: blink timing
    issue(0, 0, 8'h0E);
    issue(0, 0, 8'h0F);
    n = 0;
    for (int k = 0; k < 4 * HALF; k++) begin
      if (k == 0) chk("R12 starts dark", blinkLit, 0);
      if (k == HALF) chk("R12 first lit", blinkLit, 1);
      n += int'(blinkLit);
      @(negedge clk);
    end
    chk("R12 duty", n, 2 * HALF);
    issue(0, 0, 8'h0C);
    chk("R12 off dark", blinkLit, 0);

    // R2 R3: clear with traffic behind it
    issue(0, 0, 8'h04);
    issue(0, 0, 8'h18);
    issue(0, 0, 8'h80 | 8'h45);
    issue(0, 0, 8'h01);
    c0 = cyc;
    issue(0, 0, 8'h20);
    issue(1, 0, 8'h02);
    issue(0, 1, 8'h00);
    chk("R3 status busy", lastRd, 8'h80);
    waitIdle(n);
    chk("R2 fill length", cyc - c0, 80);
    chk("R3 width kept", wideBus, 1);
    chk("R3 brightness kept", brightness, 3);
    chk("R2 addr", {cgSel, acAddr}, 0);
    chk("R2 shift", shiftOff, 0);
    for (int i = 0; i < 128; i++) model[i] = 8'h20;
    scanAll("R2 blank");
    issue(1, 0, 8'h55);
    chk("R2 forced increment", acAddr, 7'h01);
    scanAddr = 7'h00; #1;
    chk("R2 write after clear", scanChar, 8'h55);
    scanAddr = 7'h28; #1;
    chk("R14 column 40 blank", scanChar, 8'h20);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule